// File: doc/BRIEF.md
# I2C Byte Shift Register

This block holds the single byte that an I2C controller is sending or receiving and moves it one bit per SCL clock. Software loads a byte through a small register port. On every sampled SCL rising event, the register shifts left by one place and takes the current line value into bit 0. The same left shift drives the transmit side: bit 7 is presented on the serial output at each SCL falling event, so the most significant bit leaves first. Because the register is filled from the line it drives, it also reads back what actually appeared on the bus.

The bit taken from the line passes through a synchronizer of `SYNC_STAGES` system clocks, which must be at least 2. A counter tracks how many bits have been shifted. Once eight bits have moved, the counter raises a byte-complete flag and the register stops shifting until software writes it again. When the interface is in master mode, a write also sends a one-cycle request to the SCL generator.

Top module: `i2c_byte_shifter`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is: register 0, `bit_cnt` 0, `byte_done` 0, `start_clk` 0 and `sda_out` 1.
- R2: Each accepted capture shifts the register left by one place and loads bit 0 with the `sda_in` value sampled at the same edge as the `scl_rise` pulse. It also raises `bit_cnt` by one.
- R3: With `SYNC_STAGES` = 2, a capture shows in `cpu_rdata` after the second clock edge that follows the edge at which `scl_rise` was sampled high. It never shows earlier.
- R4: A `cpu_wr` pulse loads `cpu_wdata` into the register only while `en` is 1. While `en` is 0, the register and `bit_cnt` keep their values.
- R5: An accepted write clears `bit_cnt` to 0. If it falls in the same cycle as a capture, the write wins.
- R6: `start_clk` is high for exactly the one cycle after a write that is made with both `en` and `master` at 1. It is 0 at all other times.
- R7: `cpu_rdata` always shows the register contents, whatever the value of `en`.
- R8: `sda_out` changes only at the clock edge after an `scl_fall` pulse. While `bit_cnt` is below 8, it then takes register bit 7, so the first bit written out is the MSB.
- R9: `bit_cnt` never goes above 8. `byte_done` is 1 exactly when `bit_cnt` is 8. A rising event that arrives at 8 leaves the register unchanged.
- R10: A falling event that arrives while `bit_cnt` is 8 sets `sda_out` to 1, releasing the line.
- R11: While `en` is 0, rising events capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register contents |
| en | input | 1 | Interface enable |
| master | input | 1 | Master mode select |
| scl_rise | input | 1 | One-cycle SCL rising event |
| scl_fall | input | 1 | One-cycle SCL falling event |
| sda_in | input | 1 | Serial line input |
| sda_out | output | 1 | Serial line output, 1 = released |
| bit_cnt | output | 4 | Bits shifted since the last write |
| byte_done | output | 1 | Eight bits shifted |
| start_clk | output | 1 | One-cycle request to start SCL generation |

## Verification
The checks cover five kinds of input:
- A loopback transmit of 0xA5, where `sda_in` follows `sda_out`. It shows MSB-first order and separates a correct left shift from a right shift or a shift with the wrong fill bit.
- Checks of the register in the two cycles after each rising event. These show whether the synchronizer depth is correct, and would catch a capture that came too early or too late.
- Writes made with `en` low, rises made with `en` low, and rises made after the byte is complete. Each must leave the readback, the count and the serial output unchanged.
- A write placed in the same cycle as a capture, to show which of the two takes effect.
- A long random mix of writes, rises, falls and changes to `en` and `master`. It is compared against a reference model in the bench.

// File: rtl/i2c_sr_pkg.sv
package i2c_sr_pkg;
  localparam int unsigned SR_W  = 8;
  localparam int unsigned CNT_W = $clog2(SR_W + 1);

  // Left shift with a new bit entering at position 0.
  function automatic logic [SR_W-1:0] f_shift_in(input logic [SR_W-1:0] cur,
                                                 input logic            b);
    return {cur[SR_W-2:0], b};
  endfunction

  // Counter step: a clear wins, otherwise the count rises up to SR_W and stops there.
  function automatic logic [CNT_W-1:0] f_cnt_next(input logic [CNT_W-1:0] cur,
                                                  input logic             clr,
                                                  input logic             inc);
    if (clr) return '0;
    if (inc && (cur != CNT_W'(SR_W))) return cur + 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/i2c_sr_sync.sv
module i2c_sr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_in,
  input  logic din,
  output logic rise_out,
  output logic dout
);
  logic [STAGES-1:0] rise_q;
  logic [STAGES-1:0] data_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q[0] <= 1'b0;
          data_q[0] <= 1'b1;
        end else begin
          rise_q[0] <= rise_in;
          data_q[0] <= din;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q[i] <= 1'b0;
          data_q[i] <= 1'b1;
        end else begin
          rise_q[i] <= rise_q[i-1];
          data_q[i] <= data_q[i-1];
        end
      end
    end
  end

  assign rise_out = rise_q[STAGES-1];
  assign dout     = data_q[STAGES-1];
endmodule

// File: rtl/i2c_sr_bitcnt.sv
module i2c_sr_bitcnt
  import i2c_sr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= f_cnt_next(cnt, clr, inc);
  end

  assign full = (cnt == CNT_W'(SR_W));
endmodule

// File: rtl/i2c_sr_txout.sv
module i2c_sr_txout (
  input  logic clk,
  input  logic rst,
  input  logic fall,
  input  logic msb,
  input  logic full,
  output logic sda
);
  always_ff @(posedge clk) begin
    if (rst)       sda <= 1'b1;
    else if (fall) sda <= full ? 1'b1 : msb;
  end
endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter
  import i2c_sr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [SR_W-1:0]  cpu_wdata,
  output logic [SR_W-1:0]  cpu_rdata,
  input  logic             en,
  input  logic             master,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_in,
  output logic             sda_out,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             byte_done,
  output logic             start_clk
);
  logic [SR_W-1:0] shreg;
  logic            rise_sync;
  logic            sda_bit;
  logic            wr_accept;
  logic            cap_evt;

  i2c_sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rise_in(scl_rise), .din(sda_in),
    .rise_out(rise_sync), .dout(sda_bit)
  );

  // Named internal events, brought out for the checker.
  assign wr_accept = cpu_wr & en;
  assign cap_evt   = rise_sync & en & ~byte_done & ~wr_accept;

  i2c_sr_bitcnt u_cnt (
    .clk(clk), .rst(rst), .clr(wr_accept), .inc(cap_evt),
    .cnt(bit_cnt), .full(byte_done)
  );

  always_ff @(posedge clk) begin
    if (rst)            shreg <= '0;
    else if (wr_accept) shreg <= cpu_wdata;
    else if (cap_evt)   shreg <= f_shift_in(shreg, sda_bit);
  end

  always_ff @(posedge clk) begin
    if (rst) start_clk <= 1'b0;
    else     start_clk <= wr_accept & master;
  end

  i2c_sr_txout u_tx (
    .clk(clk), .rst(rst), .fall(scl_fall), .msb(shreg[SR_W-1]),
    .full(byte_done), .sda(sda_out)
  );

  assign cpu_rdata = shreg;
endmodule

// File: rtl/i2c_byte_shifter_chk.sv
module i2c_byte_shifter_chk
  import i2c_sr_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             cpu_wr,
  input logic [SR_W-1:0]  cpu_wdata,
  input logic [SR_W-1:0]  cpu_rdata,
  input logic             en,
  input logic             master,
  input logic             scl_fall,
  input logic             sda_out,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             byte_done,
  input logic             start_clk,
  input logic             wr_accept,
  input logic             cap_evt,
  input logic             sda_bit
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (cpu_rdata == '0) && (bit_cnt == '0) && !start_clk && sda_out);

  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (cpu_rdata == {$past(cpu_rdata[SR_W-2:0]), $past(sda_bit)})
                && (bit_cnt == $past(bit_cnt) + 1'b1));

  p_write_load_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && en) |=> cpu_rdata == $past(cpu_wdata));

  p_write_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !en) |=> $stable(cpu_rdata) && $stable(bit_cnt));

  p_write_clears_r5: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> bit_cnt == '0);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && en && master) |=> start_clk);

  p_start_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(cpu_wr && en && master) |=> !start_clk);

  p_sda_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !scl_fall |=> $stable(sda_out));

  p_cnt_limit_r9: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(SR_W));

  p_hold_full_r9: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !wr_accept) |=> $stable(cpu_rdata));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && byte_done) |=> sda_out);

  p_no_cap_off_r11: assert property (@(posedge clk) disable iff (rst)
    !en |-> !cap_evt);
endmodule

bind i2c_byte_shifter i2c_byte_shifter_chk u_chk (.*);

// File: tb/i2c_byte_shifter_tb.sv
module i2c_byte_shifter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       en = 1'b0;
  logic       master = 1'b0;
  logic       scl_rise = 1'b0;
  logic       scl_fall = 1'b0;
  logic       sda_in = 1'b1;
  logic       sda_out;
  logic [3:0] bit_cnt;
  logic       byte_done;
  logic       start_clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_reg;
  logic [3:0] m_cnt;
  logic       m_sda;

  always #2 clk = ~clk;

  i2c_byte_shifter u_dut (.*);

  function automatic logic [7:0] ref_shift(input logic [7:0] v, input logic b);
    ref_shift = (v << 1) | {7'd0, b};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_state(input string req);
    chk(cpu_rdata == m_reg, req, cpu_rdata, m_reg);
    chk(bit_cnt == m_cnt, req, bit_cnt, m_cnt);
    chk(byte_done == (m_cnt == 4'd8), req, byte_done, m_cnt == 4'd8);
    chk(sda_out == m_sda, req, sda_out, m_sda);
  endtask

  task automatic do_write(input logic [7:0] d);
    bit exp_start;
    cpu_wr = 1'b1; cpu_wdata = d;
    exp_start = en & master;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (en) begin m_reg = d; m_cnt = 0; end
    chk(start_clk == exp_start, "R6 start pulse", start_clk, exp_start);
    cmp_state("R4 R5 write");
    @(negedge clk);
    chk(start_clk == 1'b0, "R6 pulse width", start_clk, 0);
  endtask

  task automatic do_rise(input logic b);
    scl_rise = 1'b1; sda_in = b;
    @(negedge clk);
    scl_rise = 1'b0; sda_in = ~b;
    chk(cpu_rdata == m_reg, "R3 no early capture", cpu_rdata, m_reg);
    @(negedge clk);
    chk(cpu_rdata == m_reg, "R3 no early capture", cpu_rdata, m_reg);
    @(negedge clk);
    if (en && m_cnt != 4'd8) begin
      m_reg = ref_shift(m_reg, b);
      m_cnt++;
    end
    cmp_state("R2 R9 R11 capture");
  endtask

  task automatic do_fall();
    scl_fall = 1'b1;
    @(negedge clk);
    scl_fall = 1'b0;
    m_sda = (m_cnt == 4'd8) ? 1'b1 : m_reg[7];
    chk(sda_out == m_sda, "R8 R10 sda after fall", sda_out, m_sda);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] tx;
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_reg = '0; m_cnt = '0; m_sda = 1'b1;
    cmp_state("R1 reset");
    chk(start_clk == 1'b0, "R1 reset start", start_clk, 0);

    // R8 MSB-first transmit with loopback of 0xA5
    en = 1'b1; master = 1'b1;
    tx = 8'hA5;
    do_write(tx);
    for (int i = 0; i < 8; i++) begin
      do_fall();
      chk(sda_out == tx[7-i], "R8 msb first", sda_out, tx[7-i]);
      do_rise(sda_out);
    end
    chk(cpu_rdata == tx, "R2 loopback readback", cpu_rdata, tx);
    chk(byte_done == 1'b1, "R9 byte done", byte_done, 1);
    do_rise(1'b0);  // R9 ignored when full
    do_fall();      // R10 released
    chk(sda_out == 1'b1, "R10 release", sda_out, 1);

    // R4 R7: writes ignored while disabled, readback still works
    en = 1'b0;
    do_write(8'h3C);
    chk(cpu_rdata == tx, "R7 read while disabled", cpu_rdata, tx);
    // R11: rises ignored while disabled
    en = 1'b1; master = 1'b0;
    do_write(8'h0F);
    en = 1'b0;
    do_rise(1'b1);
    en = 1'b1;

    // R5: a write colliding with a capture wins
    scl_rise = 1'b1; sda_in = 1'b1;
    @(negedge clk);
    scl_rise = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = 8'h96;
    @(negedge clk);
    cpu_wr = 1'b0;
    m_reg = 8'h96; m_cnt = 0;
    cmp_state("R5 write beats capture");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int unsigned op;
      op = $urandom % 10;
      if (op < 2) begin
        en = ($urandom % 4) != 0;
        master = $urandom % 2;
        do_write(8'($urandom));
      end else if (op < 8) begin
        do_rise(1'($urandom));
        do_fall();
      end else if (op == 8) begin
        en = $urandom % 2;
        @(negedge clk);
      end else begin
        do_fall();
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule